// File: doc/BRIEF.md
# Posted-Write Queue with Read Bypass

This block holds stores that a data cache has posted toward main memory, so the processor need not wait for memory to accept each write. The cache hands an address and a 32-bit word to the queue. The queue then offers the oldest held write to memory over a valid/ready handshake. It sends writes strictly in arrival order and runs at whatever pace memory sets.

When the cache misses on a read, it presents the missing word address on a lookup port before it goes to memory. A policy input selects one of two behaviours. In stall mode, the lookup reports busy until every posted write has reached memory. In bypass mode, the read may go ahead of the queued writes. A search over all held addresses then returns the newest queued value for that address, so the cache never takes a stale word from memory.

The bypass path also supports a write-back cache that evicts a dirty line. The cache posts the dirty line first. It then looks up and fetches the missing line while the victim write is still queued, and memory receives the victim write afterwards.

Top module: `wr_drain_queue`

## Requirements
- R1: After reset, and at once whenever reset is asserted, the queue holds nothing. `full` is 0, `mem_valid` is 0 and no lookup hits.
- R2: A write offered while `full` is 0 is accepted in that cycle. Its full word address (AW bits) and its 32-bit datum later appear unchanged on `mem_addr` and `mem_data`.
- R3: With DEPTH (4) writes held, `full` is 1. A write offered while `full` is 1 is refused and is never stored, even if an entry drains in the same cycle.
- R4: `mem_valid` is 1 exactly while at least one write is held. `mem_addr` and `mem_data` show the oldest held write and stay stable until a cycle with `mem_ready` at 1 removes it. Writes leave in arrival order.
- R5: With `rd_policy` = 1 (bypass) and `lk_req` at 1, `lk_hit` is 1 when a held write matches `lk_addr`, and `lk_data` then carries its datum. With no match, `lk_hit` and `lk_data` are 0 and `lk_busy` is 0.
- R6: Writes to the same address are held as separate entries and each is sent to memory. A lookup matching several of them returns the datum of the most recently accepted one.
- R7: With `rd_policy` = 0 (stall) and `lk_req` at 1, `lk_busy` is 1 while any write is held or a write is accepted in that cycle, and `lk_hit` is 0. `lk_busy` is 0 once the queue is empty.
- R8: Within one cycle, a lookup also sees a write accepted in that same cycle, as the newest entry. It also still sees the entry that memory removes in that cycle.
- R9: In bypass mode, a lookup for an address not held returns `lk_busy` 0 and `lk_hit` 0 while an earlier posted victim stays queued. The victim reaches memory after that lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_policy | input | 1 | Read-miss policy: 0 stall until empty, 1 bypass with search |
| enq_valid | input | 1 | Cache offers a write |
| enq_addr | input | AW | Word address of the offered write |
| enq_data | input | DW | Datum of the offered write |
| full | output | 1 | Queue holds DEPTH writes; offers are refused |
| lk_req | input | 1 | Read-miss lookup request |
| lk_addr | input | AW | Word address of the read miss |
| lk_hit | output | 1 | A held write matches the lookup |
| lk_data | output | DW | Newest matching datum, 0 when no hit |
| lk_busy | output | 1 | Stall mode: read must wait |
| mem_valid | output | 1 | A write is offered to memory |
| mem_addr | output | AW | Address of the oldest held write |
| mem_data | output | DW | Datum of the oldest held write |
| mem_ready | input | 1 | Memory accepts the offered write |

## Verification
A lookup can coincide with a write being accepted, and also with the oldest entry being removed by memory. Both cases decide whether a read sees a value that is just arriving or just leaving. The stimulus table deliberately puts a matching enqueue and a lookup in the same cycle, and a lookup of the draining entry together with `mem_ready` high. The bench judges each cycle from the queue contents it tracks by hand: the same-cycle write must win as the newest match, and the departing entry must still hit. A directed sequence repeats both at once on one address, and the checker separately confirms that stall mode never reports a hit while writes remain.

// File: rtl/wdq_pkg.sv
package wdq_pkg;
  // read-miss handling selected by the cache
  typedef enum logic {
    POL_STALL  = 1'b0,
    POL_BYPASS = 1'b1
  } rd_policy_e;
endpackage

// File: rtl/wdq_rst_sync.sv
module wdq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wdq_fifo.sv
// Circular store of posted writes; entries exposed in age order (0 = oldest).
module wdq_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [CW-1:0]              occ,
  output logic [DEPTH-1:0]           age_vld,
  output logic [DEPTH-1:0][AW-1:0]   age_addr,
  output logic [DEPTH-1:0][DW-1:0]   age_data
);
  logic [DEPTH-1:0]         slot_vld_q, slot_vld_d;
  logic [PW-1:0]            head_q, head_d;
  logic [PW-1:0]            tail_q, tail_d;
  logic [CW-1:0]            occ_q, occ_d;
  logic [DEPTH-1:0][AW-1:0] slot_addr_q;
  logic [DEPTH-1:0][DW-1:0] slot_data_q;

  // next state
  always_comb begin
    head_d     = head_q;
    tail_d     = tail_q;
    occ_d      = occ_q;
    slot_vld_d = slot_vld_q;
    if (pop) begin
      slot_vld_d[head_q] = 1'b0;
      head_d             = head_q + 1'b1;
    end
    if (push) begin
      slot_vld_d[tail_q] = 1'b1;
      tail_d             = tail_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld_q <= '0;
      head_q     <= '0;
      tail_q     <= '0;
      occ_q      <= '0;
    end else begin
      slot_vld_q <= slot_vld_d;
      head_q     <= head_d;
      tail_q     <= tail_d;
      occ_q      <= occ_d;
    end
  end

  // payload registers, written only on an accepted push
  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr_q[tail_q] <= push_addr;
      slot_data_q[tail_q] <= push_data;
    end
  end

  // rotate physical slots into age order
  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [PW-1:0] idx;
    assign idx         = head_q + PW'(g);
    assign age_vld[g]  = slot_vld_q[idx];
    assign age_addr[g] = slot_addr_q[idx];
    assign age_data[g] = slot_data_q[idx];
  end

  assign occ = occ_q;
endmodule

// File: rtl/wdq_cam.sv
// Associative search over held writes; the newest match wins, and a write
// accepted in the same cycle counts as newer than every held entry.
module wdq_cam #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32
) (
  input  logic [DEPTH-1:0]           age_vld,
  input  logic [DEPTH-1:0][AW-1:0]   age_addr,
  input  logic [DEPTH-1:0][DW-1:0]   age_data,
  input  logic [AW-1:0]              key,
  input  logic                       fwd_vld,
  input  logic [AW-1:0]              fwd_addr,
  input  logic [DW-1:0]              fwd_data,
  output logic                       hit,
  output logic [DW-1:0]              hit_data
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = age_vld[g] && (age_addr[g] == key);
  end

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        hit      = 1'b1;
        hit_data = age_data[i];
      end
    end
    if (fwd_vld && (fwd_addr == key)) begin
      hit      = 1'b1;
      hit_data = fwd_data;
    end
  end
endmodule

// File: rtl/wr_drain_queue.sv
module wr_drain_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_policy,
  input  logic          enq_valid,
  input  logic [AW-1:0] enq_addr,
  input  logic [DW-1:0] enq_data,
  output logic          full,
  input  logic          lk_req,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  output logic          lk_busy,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready
);
  import wdq_pkg::*;

  logic                     srst_n;
  logic                     push, pop;
  logic [CW-1:0]            occ;
  logic [DEPTH-1:0]         age_vld;
  logic [DEPTH-1:0][AW-1:0] age_addr;
  logic [DEPTH-1:0][DW-1:0] age_data;
  logic                     cam_hit;
  logic [DW-1:0]            cam_data;
  logic                     bypass_mode;

  wdq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign full      = (occ == CW'(DEPTH));
  assign mem_valid = (occ != '0);
  assign push      = enq_valid && !full;
  assign pop       = mem_valid && mem_ready;

  wdq_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst_n     (srst_n),
    .push      (push),
    .push_addr (enq_addr),
    .push_data (enq_data),
    .pop       (pop),
    .occ       (occ),
    .age_vld   (age_vld),
    .age_addr  (age_addr),
    .age_data  (age_data)
  );

  assign mem_addr = age_addr[0];
  assign mem_data = age_data[0];

  wdq_cam #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_cam (
    .age_vld  (age_vld),
    .age_addr (age_addr),
    .age_data (age_data),
    .key      (lk_addr),
    .fwd_vld  (push),
    .fwd_addr (enq_addr),
    .fwd_data (enq_data),
    .hit      (cam_hit),
    .hit_data (cam_data)
  );

  assign bypass_mode = (rd_policy == POL_BYPASS);
  assign lk_busy     = lk_req && !bypass_mode && (mem_valid || push);
  assign lk_hit      = lk_req && bypass_mode && cam_hit;
  assign lk_data     = lk_hit ? cam_data : '0;
endmodule

// File: rtl/wdq_checker.sv
module wdq_checker #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          srst_n,
  input logic          rd_policy,
  input logic          enq_valid,
  input logic          full,
  input logic          lk_req,
  input logic          lk_hit,
  input logic          lk_busy,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic [CW-1:0] occ
);
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (!mem_valid && !full));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!srst_n)
    occ <= CW'(DEPTH));

  assert_full_refuse_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (full && enq_valid && !mem_ready) |=> (full && occ == $past(occ)));

  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  assert_empty_nohit_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (lk_req && !mem_valid && !enq_valid) |-> !lk_hit);

  assert_stall_busy_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (lk_req && !rd_policy && mem_valid) |-> (lk_busy && !lk_hit));

  assert_bypass_free_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (lk_req && rd_policy) |-> !lk_busy);
endmodule

bind wr_drain_queue wdq_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .rd_policy (rd_policy),
  .enq_valid (enq_valid),
  .full      (full),
  .lk_req    (lk_req),
  .lk_hit    (lk_hit),
  .lk_busy   (lk_busy),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .occ       (occ)
);

// File: tb/wr_drain_queue_tb.sv
module wr_drain_queue_tb;
  localparam int AW = 30;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          rd_policy;
  logic          enq_valid;
  logic [AW-1:0] enq_addr;
  logic [DW-1:0] enq_data;
  logic          full;
  logic          lk_req;
  logic [AW-1:0] lk_addr;
  logic          lk_hit;
  logic [DW-1:0] lk_data;
  logic          lk_busy;
  logic          mem_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic          mem_ready;

  int n_chk;
  int n_bad;

  wr_drain_queue u_dut (
    .clk(clk), .rst_n(rst_n), .rd_policy(rd_policy),
    .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_data(enq_data), .full(full),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .lk_busy(lk_busy), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  typedef struct packed {
    logic        en;  logic [7:0] ea; logic [31:0] ed;
    logic        lr;  logic [7:0] la; logic byp; logic mr;
    logic        xfull; logic xmv; logic [7:0] xma; logic [31:0] xmd;
    logic        xhit;  logic [31:0] xld; logic xbusy;
  } vec_t;

  // one row per cycle, starting from an empty queue
  localparam vec_t VEC [10] = '{
    '{1'b1, 8'h10, 32'hA0, 1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h00, 1'b1, 32'hA0, 1'b0},
    '{1'b1, 8'h20, 32'hB0, 1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 8'h10, 32'hA0, 1'b1, 32'hA0, 1'b0},
    '{1'b1, 8'h10, 32'hC0, 1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 8'h10, 32'hA0, 1'b1, 32'hC0, 1'b0},
    '{1'b1, 8'h30, 32'hD0, 1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 8'h10, 32'hA0, 1'b1, 32'hC0, 1'b0},
    '{1'b1, 8'h40, 32'hE0, 1'b1, 8'h40, 1'b1, 1'b0, 1'b1, 1'b1, 8'h10, 32'hA0, 1'b0, 32'h00, 1'b0},
    '{1'b0, 8'h00, 32'h00, 1'b1, 8'h50, 1'b0, 1'b1, 1'b1, 1'b1, 8'h10, 32'hA0, 1'b0, 32'h00, 1'b1},
    '{1'b0, 8'h00, 32'h00, 1'b1, 8'h20, 1'b1, 1'b1, 1'b0, 1'b1, 8'h20, 32'hB0, 1'b1, 32'hB0, 1'b0},
    '{1'b0, 8'h00, 32'h00, 1'b1, 8'h10, 1'b1, 1'b1, 1'b0, 1'b1, 8'h10, 32'hC0, 1'b1, 32'hC0, 1'b0},
    '{1'b0, 8'h00, 32'h00, 1'b1, 8'h40, 1'b1, 1'b1, 1'b0, 1'b1, 8'h30, 32'hD0, 1'b0, 32'h00, 1'b0},
    '{1'b0, 8'h00, 32'h00, 1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h00, 1'b0, 32'h00, 1'b0}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, leave outputs 1 ns to settle
  task automatic step(input logic en, input logic [AW-1:0] ea, input logic [DW-1:0] ed,
                      input logic lr, input logic [AW-1:0] la, input logic byp,
                      input logic mr);
    @(negedge clk);
    enq_valid = en; enq_addr = ea; enq_data = ed;
    lk_req = lr; lk_addr = la; rd_policy = byp; mem_ready = mr;
    #1;
  endtask

  task automatic idle();
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 full in reset", 32'(full), 32'h0);
    chk("R1 mem_valid in reset", 32'(mem_valid), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; rd_policy = 1'b1; enq_valid = 1'b0; enq_addr = '0; enq_data = '0;
    lk_req = 1'b0; lk_addr = '0; mem_ready = 1'b0;
    do_reset();

    // R1: empty after reset release, nothing hits
    step(1'b0, '0, '0, 1'b1, 30'h10, 1'b1, 1'b0);
    chk("R1 full after reset", 32'(full), 32'h0);
    chk("R1 mem_valid after reset", 32'(mem_valid), 32'h0);
    chk("R1 no hit after reset", 32'(lk_hit), 32'h0);

    // table: R3 full, R4 drain order/hold, R5 lookup, R6 youngest, R7 busy, R8 same cycle
    foreach (VEC[i]) begin
      step(VEC[i].en, AW'(VEC[i].ea), VEC[i].ed, VEC[i].lr, AW'(VEC[i].la),
           VEC[i].byp, VEC[i].mr);
      chk($sformatf("R3 full row %0d", i), 32'(full), 32'(VEC[i].xfull));
      chk($sformatf("R4 mem_valid row %0d", i), 32'(mem_valid), 32'(VEC[i].xmv));
      if (VEC[i].xmv) begin
        chk($sformatf("R4 mem_addr row %0d", i), 32'(mem_addr), 32'(VEC[i].xma));
        chk($sformatf("R4 mem_data row %0d", i), mem_data, VEC[i].xmd);
      end
      chk($sformatf("R5 lk_hit row %0d", i), 32'(lk_hit), 32'(VEC[i].xhit));
      chk($sformatf("R5 lk_data row %0d", i), lk_data, VEC[i].xld);
      chk($sformatf("R7 lk_busy row %0d", i), 32'(lk_busy), 32'(VEC[i].xbusy));
    end

    // R7: stall mode, busy on same-cycle enqueue into empty queue, clears when drained
    step(1'b1, 30'h60, 32'h61, 1'b1, 30'h60, 1'b0, 1'b0);
    chk("R7 busy on enqueue cycle", 32'(lk_busy), 32'h1);
    chk("R7 no hit in stall mode", 32'(lk_hit), 32'h0);
    step(1'b0, '0, '0, 1'b1, 30'h60, 1'b0, 1'b1);
    chk("R7 busy while held", 32'(lk_busy), 32'h1);
    step(1'b0, '0, '0, 1'b1, 30'h60, 1'b0, 1'b0);
    chk("R7 not busy when empty", 32'(lk_busy), 32'h0);

    // R9: dirty victim posted, missing line read first, victim drains after
    step(1'b1, 30'h77, 32'h99, 1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, '0, 1'b1, 30'h88, 1'b1, 1'b0);
    chk("R9 read not busy", 32'(lk_busy), 32'h0);
    chk("R9 read misses victim", 32'(lk_hit), 32'h0);
    chk("R9 victim still queued", 32'(mem_valid), 32'h1);
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, 1'b1);
    chk("R9 victim addr after read", 32'(mem_addr), 32'h77);
    chk("R9 victim data after read", mem_data, 32'h99);
    idle();
    chk("R9 victim gone", 32'(mem_valid), 32'h0);

    // R6: same address twice, no merge, youngest returned, both drain in order
    step(1'b1, 30'h5, 32'hD1, 1'b0, '0, 1'b1, 1'b0);
    step(1'b1, 30'h5, 32'hD2, 1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, '0, 1'b1, 30'h5, 1'b1, 1'b1);
    chk("R6 youngest data", lk_data, 32'hD2);
    chk("R6 first drain", mem_data, 32'hD1);
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, 1'b1);
    chk("R6 second entry kept", 32'(mem_valid), 32'h1);
    chk("R6 second drain", mem_data, 32'hD2);
    idle();
    chk("R6 empty after both", 32'(mem_valid), 32'h0);

    // R8: lookup while same address drains and a newer write arrives
    step(1'b1, 30'h9, 32'h91, 1'b0, '0, 1'b1, 1'b0);
    step(1'b1, 30'h9, 32'h92, 1'b1, 30'h9, 1'b1, 1'b1);
    chk("R8 same-cycle enqueue wins", lk_data, 32'h92);
    chk("R8 draining entry", mem_data, 32'h91);
    step(1'b0, '0, '0, 1'b1, 30'h9, 1'b1, 1'b1);
    chk("R8 draining entry still hits", 32'(lk_hit), 32'h1);
    chk("R8 draining entry data", lk_data, 32'h92);
    idle();

    // R2: full-width address and datum pass through unchanged
    step(1'b1, 30'h2AAA_AAAA, 32'hDEAD_BEEF, 1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, 1'b1);
    chk("R2 full-width addr", 32'(mem_addr), 32'h2AAA_AAAA);
    chk("R2 full-width data", mem_data, 32'hDEAD_BEEF);
    idle();

    // R1: reset with writes held empties the queue
    step(1'b1, 30'h33, 32'h44, 1'b0, '0, 1'b1, 1'b0);
    step(1'b1, 30'h35, 32'h46, 1'b0, '0, 1'b1, 1'b0);
    enq_valid = 1'b0;
    do_reset();
    step(1'b0, '0, '0, 1'b1, 30'h33, 1'b1, 1'b0);
    chk("R1 empty after mid-run reset", 32'(mem_valid), 32'h0);
    chk("R1 no hit after mid-run reset", 32'(lk_hit), 32'h0);

    summary();
    $finish;
  end
endmodule